// File: doc/BRIEF.md
# Sync-Gated Bit Error Tally

This block measures the bit error rate of a serial stream against a known-good copy of the same stream. Two bit streams arrive on separate ports, each with its own valid strobe: `ref_bit` carries the reference bits and `dut_bit` carries the bits under measurement. The two streams are assumed to be aligned already. A bit pair is taken only in a cycle where both strobes are high.

Counting is held off until a programmable sync word has been found on the measured stream. The search is an exact match over its most recent bits. Once the word has been found, the gate opens. From then on every bit pair is XORed. A 1 adds to the error count and a 0 adds to the correct-bit count. The gate stays open until `clear` is pulsed.

Both counts are exposed, together with a numerator and a denominator. The error rate is numerator divided by denominator. The division is left to whatever reads the outputs.

Top module: `ber_xor_tally`

## Requirements
- R1: After synchronous active-low reset, `gate_open` is 0 and `err_count`, `ok_count`, `ber_num` and `ber_den` are all 0.
- R2: A bit pair is consumed only in a cycle where `ref_valid` and `dut_valid` are both 1. In any other cycle the sync search, the gate and the counts do not change.
- R3: While the gate is closed, the gate opens on the clock edge that consumes a pair completing a match, and `gate_open` reads 1 after that edge. A match means that the most recent L consumed `dut_bit` values equal `sync_word[L-1:0]`, with `sync_word[L-1]` the oldest bit and `sync_word[0]` the newest. `ref_bit` plays no part in the search.
- R4: The pairs that carry the sync word are not counted. While the gate is closed, both counts stay 0. The first pair counted is the first pair consumed after the gate opens.
- R5: While the gate is open, a consumed pair with `ref_bit != dut_bit` adds 1 to `err_count`, and a pair with equal bits adds 1 to `ok_count`. The new value is visible after the consuming clock edge.
- R6: `ber_num` equals `err_count`. `ber_den` equals `err_count + ok_count` and is one bit wider than a count, so the sum never wraps.
- R7: Once open, the gate stays open whatever bits arrive, until `clear` is pulsed.
- R8: A `clear` pulse closes the gate, zeros both counts and discards the sync search history. It takes priority over a pair consumed in the same cycle, and that pair is neither counted nor searched.
- R9: Each count saturates at 2^CNT_W-1 and holds there while further pairs of its kind arrive.
- R10: The effective length L equals `sync_len`, limited to SYNC_MAX. When `sync_len` is 0, the first pair consumed while the gate is closed opens it, and that pair is not counted.
- R11: A match needs at least L pairs consumed since the last reset or `clear`. Older history is treated as absent, not as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Closes the gate, zeros the counts and restarts the sync search |
| ref_bit | input | 1 | Reference (known-good) bit |
| ref_valid | input | 1 | Reference bit strobe |
| dut_bit | input | 1 | Bit under measurement |
| dut_valid | input | 1 | Measured bit strobe |
| sync_word | input | SYNC_MAX | Sync pattern; bit 0 is the newest bit of the match |
| sync_len | input | clog2(SYNC_MAX+1) | Sync pattern length in bits |
| gate_open | output | 1 | 1 once the sync word has been found |
| err_count | output | CNT_W | Saturating count of XOR ones |
| ok_count | output | CNT_W | Saturating count of XOR zeros |
| ber_num | output | CNT_W | Error rate numerator |
| ber_den | output | CNT_W+1 | Error rate denominator |

## Verification
On every cycle, the assertions check the following:
- both counts stay zero while the gate is closed;
- an open gate stays open without a clear;
- a clear leaves the block closed and empty;
- a saturated error count never wraps;
- the denominator never moves without a consumed pair and never grows by more than one per cycle.

Where exactly the gate opens can only be shown by the bench's scenarios. The bench sweeps every sync word of every length up to the small configured maximum, preceded by noise bits. Its scenarios also cover:
- the pre-fill rule;
- the zero-length and over-length settings;
- a clear that collides with a valid pair;
- the error/correct split under mixed payload patterns.

// File: rtl/ber_pkg.sv
// Shared types for the sync-gated bit error tally.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ber_pkg;

    // Gate state: counting is enabled only in GATE_OPEN.
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_t;

endpackage

// File: rtl/ber_sync_hunt.sv
// Sync word search over the measured bit stream.
// Shifts in each consumed bit while searching. It raises `hit` combinationally
// on a pair that completes an exact match of the last L bits against the
// low L bits of the word. L is limited to SYNC_MAX.
// A match needs at least L bits seen since the last reset or clear.
// Assumes SYNC_MAX >= 2.
module ber_sync_hunt #(
    parameter int SYNC_MAX = 32,
    parameter int LEN_W    = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                search_en,
    input  logic                take,
    input  logic                bit_in,
    input  logic [SYNC_MAX-1:0] word,
    input  logic [LEN_W-1:0]    len,
    output logic                hit
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(SYNC_MAX);

    logic [SYNC_MAX-1:0] hist_q;
    logic [SYNC_MAX-1:0] window;
    logic [SYNC_MAX-1:0] mask;
    logic [LEN_W-1:0]    fill_q;
    logic [LEN_W-1:0]    eff_len;
    logic [LEN_W:0]      fill_after;
    logic                fill_ok;
    logic                shift_en;

    // Limit the requested length to the window size.
    always_comb eff_len = (len > LEN_CAP) ? LEN_CAP : len;

    // One mask bit per window position, set below the effective length.
    for (genvar i = 0; i < SYNC_MAX; i++) begin : g_mask
        assign mask[i] = (LEN_W'(i) < eff_len);
    end

    // Window as it stands once the incoming bit is included.
    always_comb window = {hist_q[SYNC_MAX-2:0], bit_in};

    // Enough history, including the incoming bit, to cover the length.
    always_comb begin
        fill_after = {1'b0, fill_q} + {{LEN_W{1'b0}}, 1'b1};
        fill_ok    = fill_after >= {1'b0, eff_len};
    end

    always_comb shift_en = search_en && take && !clear;

    // Match decision on the pair being consumed this cycle.
    always_comb hit = shift_en && fill_ok && (((window ^ word) & mask) == '0);

    // History shift register and fill counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            hist_q <= window;
            if (fill_q != LEN_CAP) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ber_gate_fsm.sv
// Two-state gate. It opens on a sync hit and closes only on clear.
// Assumes `hit` is asserted only while the gate is shut.
module ber_gate_fsm
    import ber_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    output logic is_open
);

    gate_state_t state_q;
    gate_state_t state_d;

    // Next-state choice; clear wins over a hit.
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = GATE_SHUT;
        end else if (state_q == GATE_SHUT && hit) begin
            state_d = GATE_OPEN;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb is_open = (state_q == GATE_OPEN);

endmodule

// File: rtl/ber_sat_counter.sv
// Saturating up-counter with synchronous zeroing.
// Holds at all ones. Clear takes priority over increment.
module ber_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    // Count register with saturation at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ber_xor_tally.sv
// Sync-gated XOR error tally.
// ref_bit is the reference and dut_bit the measured bit. The streams are
// assumed aligned. A pair is consumed when both valids are high. After the
// sync word has been found on dut_bit, each pair is XORed into an error
// count or a correct count. Numerator and denominator of the error rate are
// exposed; the division is done outside.
module ber_xor_tally #(
    parameter int CNT_W    = 32,
    parameter int SYNC_MAX = 32,
    parameter int LEN_W    = $clog2(SYNC_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                ref_bit,
    input  logic                ref_valid,
    input  logic                dut_bit,
    input  logic                dut_valid,
    input  logic [SYNC_MAX-1:0] sync_word,
    input  logic [LEN_W-1:0]    sync_len,
    output logic                gate_open,
    output logic [CNT_W-1:0]    err_count,
    output logic [CNT_W-1:0]    ok_count,
    output logic [CNT_W-1:0]    ber_num,
    output logic [CNT_W:0]      ber_den
);

    logic take;
    logic hit;
    logic tally_en;
    logic diff;

    // A pair exists only when both streams present a bit.
    always_comb take = ref_valid && dut_valid;

    ber_sync_hunt #(
        .SYNC_MAX (SYNC_MAX),
        .LEN_W    (LEN_W)
    ) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .search_en (!gate_open),
        .take      (take),
        .bit_in    (dut_bit),
        .word      (sync_word),
        .len       (sync_len),
        .hit       (hit)
    );

    ber_gate_fsm u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .hit     (hit),
        .is_open (gate_open)
    );

    // Classify the pair: counting only behind an open gate and without clear.
    always_comb begin
        tally_en = gate_open && take && !clear;
        diff     = ref_bit ^ dut_bit;
    end

    ber_sat_counter #(.W(CNT_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (tally_en && diff),
        .count (err_count)
    );

    ber_sat_counter #(.W(CNT_W)) u_ok (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (tally_en && !diff),
        .count (ok_count)
    );

    // Ratio terms; the sum is one bit wider so it never wraps.
    always_comb begin
        ber_num = err_count;
        ber_den = {1'b0, err_count} + {1'b0, ok_count};
    end

endmodule

// File: rtl/ber_xor_tally_chk.sv
// Cycle-level properties of the tally, bound onto every instance.
module ber_xor_tally_chk #(
    parameter int CNT_W    = 32,
    parameter int SYNC_MAX = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             ref_valid,
    input logic             dut_valid,
    input logic             gate_open,
    input logic [CNT_W-1:0] err_count,
    input logic [CNT_W-1:0] ok_count,
    input logic [CNT_W:0]   ber_den
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R1: reset leaves the block closed and empty.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!gate_open && err_count == '0 && ok_count == '0));

    // R4: nothing is counted behind a closed gate.
    p_closed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> (err_count == '0 && ok_count == '0));

    // R7: an open gate stays open until clear.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && !clear) |=> gate_open);

    // R8: clear closes the gate and empties both counts.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!gate_open && err_count == '0 && ok_count == '0));

    // R9: a saturated error count holds.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_TOP && !clear) |=> err_count == CNT_TOP);

    // R2: without a full pair the total does not move.
    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ref_valid && dut_valid) && !clear) |=> $stable(ber_den));

    // R5: the total grows by at most one per consumed pair.
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ber_den >= $past(ber_den) &&
                    {1'b0, ber_den} <= {1'b0, $past(ber_den)} + 1'b1));

endmodule

bind ber_xor_tally ber_xor_tally_chk #(
    .CNT_W    (CNT_W),
    .SYNC_MAX (SYNC_MAX)
) u_chk (.*);

// File: tb/ber_xor_tally_bench.sv
`timescale 1ns/1ps
// Bench for the tally: small configuration, exhaustive sync word sweep.
module ber_xor_tally_bench;

    localparam int CW    = 4;
    localparam int SM    = 8;
    localparam int LW    = $clog2(SM + 1);
    localparam int CTOP  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          ref_bit = 1'b0, ref_valid = 1'b0;
    logic          dut_bit = 1'b0, dut_valid = 1'b0;
    logic [SM-1:0] sync_word = '0;
    logic [LW-1:0] sync_len = '0;
    logic          gate_open;
    logic [CW-1:0] err_count, ok_count, ber_num;
    logic [CW:0]   ber_den;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Requirement-level expected state.
    bit          m_gate = 1'b0;
    int          m_err = 0, m_ok = 0, m_fill = 0;
    logic [SM-1:0] m_hist = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    ber_xor_tally #(.CNT_W(CW), .SYNC_MAX(SM)) u_ber_xor_tally (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .ref_bit(ref_bit), .ref_valid(ref_valid),
        .dut_bit(dut_bit), .dut_valid(dut_valid),
        .sync_word(sync_word), .sync_len(sync_len),
        .gate_open(gate_open), .err_count(err_count), .ok_count(ok_count),
        .ber_num(ber_num), .ber_den(ber_den)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Advance the model by one clock edge according to the requirements.
    task automatic model_step(input logic r, rv, d, dv, c);
        int L;
        logic [SM-1:0] msk;
        L = (int'(sync_len) > SM) ? SM : int'(sync_len);
        msk = (L >= SM) ? '1 : SM'((1 << L) - 1);
        if (c) begin
            m_gate = 0; m_err = 0; m_ok = 0; m_hist = '0; m_fill = 0;
        end else if (rv && dv) begin
            if (m_gate) begin
                if (r != d) m_err = (m_err < CTOP) ? m_err + 1 : CTOP;
                else        m_ok  = (m_ok  < CTOP) ? m_ok  + 1 : CTOP;
            end else begin
                m_hist = {m_hist[SM-2:0], d};
                m_fill = (m_fill < SM) ? m_fill + 1 : SM;
                if (m_fill >= L && ((m_hist ^ sync_word) & msk) == '0) m_gate = 1;
            end
        end
    endtask

    // Drive one cycle at the falling edge, then compare at the next one.
    task automatic cyc(input logic r, rv, d, dv, c);
        ref_bit = r; ref_valid = rv; dut_bit = d; dut_valid = dv; clear = c;
        @(posedge clk);
        model_step(r, rv, d, dv, c);
        @(negedge clk);
        chk(gate_open == m_gate, "R3 gate_open", int'(gate_open), int'(m_gate));
        chk(int'(err_count) == m_err, "R5 err_count", int'(err_count), m_err);
        chk(int'(ok_count) == m_ok, "R5 ok_count", int'(ok_count), m_ok);
        chk(ber_num == err_count, "R6 ber_num", int'(ber_num), int'(err_count));
        chk(int'(ber_den) == m_err + m_ok, "R6 ber_den", int'(ber_den), m_err + m_ok);
    endtask

    task automatic send_sync(input int len, input logic [SM-1:0] w);
        for (int b = len - 1; b >= 0; b--) cyc(1'b0, 1'b1, w[b], 1'b1, 1'b0);
    endtask

    task automatic payload(input int n);
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], 1'b1, lfsr[0] ^ lfsr[3], 1'b1, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk(gate_open == 1'b0 && ber_den == '0, "R1 reset state",
            int'(ber_den), 0);
        rst_n = 1'b1;

        // R2: sync bits with a missing strobe are ignored.
        sync_len = LW'(4); sync_word = SM'(4'b1011);
        for (int b = 3; b >= 0; b--) cyc(1'b0, 1'b0, sync_word[b], 1'b1, 1'b0);
        for (int b = 3; b >= 0; b--) cyc(1'b0, 1'b1, sync_word[b], 1'b0, 1'b0);
        chk(gate_open == 1'b0, "R2 half-valid pairs ignored", int'(gate_open), 0);
        send_sync(4, sync_word);
        chk(gate_open == 1'b1 && ber_den == '0, "R4 sync bits not counted",
            int'(ber_den), 0);
        // R7: garbage after open keeps the gate open.
        payload(10);
        chk(gate_open == 1'b1, "R7 gate sticky", int'(gate_open), 1);

        // R8: clear collides with a valid pair.
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk(gate_open == 1'b0 && ber_den == '0, "R8 clear wins", int'(ber_den), 0);

        // R11: a zero word needs a full window first.
        sync_len = LW'(8); sync_word = '0;
        for (int k = 0; k < 7; k++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(gate_open == 1'b0, "R11 window not yet full", int'(gate_open), 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(gate_open == 1'b1, "R11 opens on eighth bit", int'(gate_open), 1);

        // R9: saturation of the error count while ok keeps counting.
        for (int k = 0; k < 20; k++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk(int'(err_count) == CTOP && int'(ok_count) == 1, "R9 err saturates",
            int'(err_count), CTOP);

        // R10: zero length opens on the first pair, which is not counted.
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        sync_len = '0;
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(gate_open == 1'b1 && ber_den == '0, "R10 zero length", int'(ber_den), 0);

        // R10: over-long length is limited to the window.
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        sync_len = LW'(12); sync_word = SM'(8'hB2);
        send_sync(8, sync_word);
        chk(gate_open == 1'b1, "R10 length limited", int'(gate_open), 1);

        // R3: sync word present only on the reference stream.
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int b = 7; b >= 0; b--) cyc(sync_word[b], 1'b1, 1'b0, 1'b1, 1'b0);
        chk(gate_open == 1'b0, "R3 reference not searched", int'(gate_open), 0);

        // R3/R5: every word of every length, with noise prefix and payload.
        for (int len = 1; len <= SM; len++) begin
            for (int w = 0; w < (1 << len); w++) begin
                cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
                sync_len = LW'(len); sync_word = SM'(w);
                for (int n = 0; n < 2; n++) cyc(1'b0, 1'b1, ~sync_word[len-1], 1'b1, 1'b0);
                send_sync(len, sync_word);
                chk(gate_open == 1'b1, "R3 open after word", int'(gate_open), 1);
                payload(5);
            end
        end

        finish_run();
    end

endmodule